// File: doc/BRIEF.md
# Paged Memory Address Translator

This block sits between a CPU that issues 16-bit local addresses and a 23-bit physical memory space. Each local address is turned into a global address in the same cycle. A few local windows display a page chosen by a page register. Other local regions always alias fixed pages. A separate access mode skips the local map and builds the address from a 7-bit global page register.

Four page registers hold the current page selections: one for RAM, one for EEPROM, one for program flash, and one global page register. They are loaded through a one-cycle write port. A new value affects translation from the clock edge that stores it.

A 2-bit mode input decides what local 0x4000–0x7FFF shows: a fixed RAM page, a fixed flash page or external space. A one-hot output reports which physical area the produced global address falls in.

Top module: `pg_xlat_top`

## Requirements
- R1: After a synchronous reset with rst_n low, the RAM page is 0xFD, the EEPROM page is 0xFE, the flash page is 0xFE and the global page is 0x00. For example, local 0x1000 translates to 0x0F_D000.
- R2: Local 0x0000–0x07FF translates to the same numeric global address.
- R3: Local 0x1000–0x1FFF translates to {3'b000, RAM page[7:0], local[11:0]}.
- R4: Local 0x0800–0x0BFF translates to {5'b00100, EEPROM page[7:0], local[9:0]}.
- R5: Local 0x8000–0xBFFF translates to {1'b1, flash page[7:0], local[13:0]}. For example, page 0xFD at 0x8000 gives 0x7F_4000.
- R6: Three local regions always alias fixed pages, whatever the page registers hold:
  - 0x0C00–0x0FFF translates to 0x13_FC00 plus local[9:0].
  - 0x2000–0x3FFF translates to 0x0F_E000 plus local[12:0].
  - 0xC000–0xFFFF translates to 0x7F_C000 plus local[13:0].
- R7: map_mode selects the target of local 0x4000–0x7FFF. The offset added in every case is local[13:0].
  - 2'b00 and 2'b11 select flash at 0x7F_4000.
  - 2'b01 selects RAM at 0x0F_C000.
  - 2'b10 selects external space at 0x14_4000.
- R8: While glob_acc is high, gaddr is {global page[6:0], local[15:0]}, whatever the local region and map_mode. A write to the global page stores wr_data[6:0], and wr_data[7] is ignored.
- R9: When wr_en is high, wr_sel picks the register loaded from wr_data: 0 is RAM, 1 is EEPROM, 2 is flash and 3 is global. The new value is used from the next rising clock edge. When wr_en is low, no page register changes.
- R10: region is one-hot and is decoded from gaddr alone:
  - bit0: registers, below 0x00_0800.
  - bit1: RAM, below 0x10_0000.
  - bit2: EEPROM, below 0x14_0000.
  - bit3: external, below 0x40_0000.
  - bit4: flash, at 0x40_0000 and above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Page register write strobe |
| wr_sel | input | 2 | Page register select (0 RAM, 1 EEPROM, 2 flash, 3 global) |
| wr_data | input | 8 | Page register write value |
| loc_addr | input | 16 | Local CPU address |
| glob_acc | input | 1 | Global-instruction access flag |
| map_mode | input | 2 | Target of local 0x4000–0x7FFF |
| gaddr | output | 23 | Translated global address |
| region | output | 5 | One-hot physical area of gaddr |

## Verification
The bench builds the translator with its default reset pages, so the unbanked aliases and the banked windows start out on neighbouring pages. A mix-up between them would then show up as an off-by-one page. Every window edge is visited under all four map_mode codes. This is repeated after page writes to 0x00, 0xFF and middle values, which brings both extreme pages of each area within reach. Global accesses run with page values that carry bit 7 set. RAM page 0x00 checks that region decoding follows the global address, even when a RAM window address falls into the register area.

// File: rtl/pg_xlat_pkg.sv
// Shared widths, select codes and global area constants for the translator.
// Assumes the 16-bit local / 23-bit global geometry; constants are derived from it.
package pg_xlat_pkg;
    localparam int LOC_W   = 16;
    localparam int GLB_W   = 23;
    localparam int PAGE_W  = 8;
    localparam int GPAGE_W = GLB_W - LOC_W;
    localparam int NUM_RGN = 5;

    // Region bit positions in the one-hot output
    localparam int RGN_REG = 0;
    localparam int RGN_RAM = 1;
    localparam int RGN_EE  = 2;
    localparam int RGN_EXT = 3;
    localparam int RGN_FL  = 4;

    // Upper bounds (exclusive) of each global area
    localparam logic [GLB_W-1:0] LIM_REG = 23'h00_0800;
    localparam logic [GLB_W-1:0] LIM_RAM = 23'h10_0000;
    localparam logic [GLB_W-1:0] LIM_EE  = 23'h14_0000;
    localparam logic [GLB_W-1:0] LIM_EXT = 23'h40_0000;

    // Fixed prefixes that place each area in the global map
    localparam logic [2:0] PFX_RAM = 3'b000;
    localparam logic [4:0] PFX_EE  = 5'b00100;
    localparam logic       PFX_FL  = 1'b1;

    // 16 KB block numbers used by the middle local quarter
    localparam logic [8:0] BLK_RAM_MID = 9'h03F;
    localparam logic [8:0] BLK_EXT_MID = 9'h051;
    localparam logic [8:0] BLK_FL_MID  = 9'h1FD;

    typedef enum logic [1:0] {
        SEL_RAM = 2'd0,
        SEL_EE  = 2'd1,
        SEL_FL  = 2'd2,
        SEL_GLB = 2'd3
    } pg_sel_e;

    typedef enum logic [1:0] {
        MAP_FLASH = 2'd0,
        MAP_RAM   = 2'd1,
        MAP_EXT   = 2'd2,
        MAP_FLALT = 2'd3
    } map_mode_e;

    typedef struct packed {
        logic [PAGE_W-1:0]  ram;
        logic [PAGE_W-1:0]  ee;
        logic [PAGE_W-1:0]  fl;
        logic [GPAGE_W-1:0] glb;
    } page_set_t;
endpackage

// File: rtl/pg_regs.sv
// Page register file: three 8-bit banked page registers and one 7-bit
// global page register, loaded through a single write port.
// Assumes synchronous active-low reset; reset values come from parameters.
module pg_regs
    import pg_xlat_pkg::*;
#(
    parameter logic [PAGE_W-1:0]  RAM_RST = 8'hFD,
    parameter logic [PAGE_W-1:0]  EE_RST  = 8'hFE,
    parameter logic [PAGE_W-1:0]  FL_RST  = 8'hFE,
    parameter logic [GPAGE_W-1:0] GLB_RST = 7'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [PAGE_W-1:0] wr_data,
    output page_set_t         pages
);
    localparam int NUM_BYTE = 3;
    localparam logic [NUM_BYTE*PAGE_W-1:0] BYTE_RST = {RAM_RST, EE_RST, FL_RST};

    logic [PAGE_W-1:0]  pg_byte [NUM_BYTE];
    logic [GPAGE_W-1:0] pg_glb;

    // Byte-wide banked page registers: slot 0 RAM, 1 EEPROM, 2 flash
    for (genvar g = 0; g < NUM_BYTE; g++) begin : g_byte
        localparam logic [PAGE_W-1:0] RST_V = BYTE_RST[(NUM_BYTE-1-g)*PAGE_W +: PAGE_W];
        // Load the slot when selected, else hold
        always_ff @(posedge clk) begin
            if (!rst_n)
                pg_byte[g] <= RST_V;
            else if (wr_en && wr_sel == 2'(g))
                pg_byte[g] <= wr_data;
        end
    end

    // Global page register keeps only the low seven data bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            pg_glb <= GLB_RST;
        else if (wr_en && wr_sel == SEL_GLB)
            pg_glb <= wr_data[GPAGE_W-1:0];
    end

    // Present the register set as one struct
    always_comb begin
        pages.ram = pg_byte[SEL_RAM];
        pages.ee  = pg_byte[SEL_EE];
        pages.fl  = pg_byte[SEL_FL];
        pages.glb = pg_glb;
    end

    p_wr_ram_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_RAM) |=> pages.ram == $past(wr_data));
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pages));
    p_glb_drop_msb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_GLB) |=> pages.glb == $past(wr_data[GPAGE_W-1:0]));
endmodule

// File: rtl/pg_local_map.sv
// Local-map translator: splits the 64 KB local space into banked windows,
// fixed aliases and a mode-selected middle quarter, and builds the global
// address. Purely combinational; assumes page values are stable per cycle.
module pg_local_map
    import pg_xlat_pkg::*;
(
    input  logic [LOC_W-1:0] loc,
    input  logic [1:0]       mode,
    input  page_set_t        pages,
    output logic [GLB_W-1:0] ga
);
    localparam logic [PAGE_W-1:0] TOP_PAGE = '1;

    logic [GLB_W-1:0] mid_ga;

    // Target of local 0x4000-0x7FFF chosen by the mapping mode
    always_comb begin
        unique case (map_mode_e'(mode))
            MAP_RAM: mid_ga = {BLK_RAM_MID, loc[13:0]};
            MAP_EXT: mid_ga = {BLK_EXT_MID, loc[13:0]};
            default: mid_ga = {BLK_FL_MID,  loc[13:0]};
        endcase
    end

    // Region decode and splice of page number and offset
    always_comb begin
        if (loc[15:11] == 5'b00000)
            ga = {{(GLB_W-LOC_W){1'b0}}, loc};
        else if (loc[15:10] == 6'b000010)
            ga = {PFX_EE, pages.ee, loc[9:0]};
        else if (loc[15:10] == 6'b000011)
            ga = {PFX_EE, TOP_PAGE, loc[9:0]};
        else if (loc[15:12] == 4'h1)
            ga = {PFX_RAM, pages.ram, loc[11:0]};
        else if (loc[15:13] == 3'b001)
            ga = {PFX_RAM, TOP_PAGE[7:1], loc[12:0]};
        else if (loc[15:14] == 2'b01)
            ga = mid_ga;
        else if (loc[15:14] == 2'b10)
            ga = {PFX_FL, pages.fl, loc[13:0]};
        else
            ga = {PFX_FL, TOP_PAGE, loc[13:0]};
    end
endmodule

// File: rtl/pg_region.sv
// Region classifier: reports, one-hot, which physical area a global
// address falls in. Assumes areas are contiguous and ordered upward.
module pg_region
    import pg_xlat_pkg::*;
(
    input  logic [GLB_W-1:0]   ga,
    output logic [NUM_RGN-1:0] hit
);
    // Compare against ascending area limits
    always_comb begin
        hit = '0;
        if (ga < LIM_REG)      hit[RGN_REG] = 1'b1;
        else if (ga < LIM_RAM) hit[RGN_RAM] = 1'b1;
        else if (ga < LIM_EE)  hit[RGN_EE]  = 1'b1;
        else if (ga < LIM_EXT) hit[RGN_EXT] = 1'b1;
        else                   hit[RGN_FL]  = 1'b1;
    end
endmodule

// File: rtl/pg_xlat_top.sv
// Paged memory address translator top: page register file, local-map
// translator, global-access bypass and region classifier.
// Assumes loc_addr, glob_acc and map_mode are valid for the whole cycle.
module pg_xlat_top
    import pg_xlat_pkg::*;
#(
    parameter logic [7:0] RAM_RST = 8'hFD,
    parameter logic [7:0] EE_RST  = 8'hFE,
    parameter logic [7:0] FL_RST  = 8'hFE,
    parameter logic [6:0] GLB_RST = 7'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [7:0]  wr_data,
    input  logic [15:0] loc_addr,
    input  logic        glob_acc,
    input  logic [1:0]  map_mode,
    output logic [22:0] gaddr,
    output logic [4:0]  region
);
    page_set_t        pages;
    logic [GLB_W-1:0] local_ga;

    pg_regs #(
        .RAM_RST(RAM_RST), .EE_RST(EE_RST), .FL_RST(FL_RST), .GLB_RST(GLB_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pages(pages)
    );

    pg_local_map u_map (
        .loc(loc_addr), .mode(map_mode), .pages(pages), .ga(local_ga)
    );

    // Global-access bypass overrides the local map
    always_comb begin
        gaddr = glob_acc ? {pages.glb, loc_addr} : local_ga;
    end

    pg_region u_rgn (
        .ga(gaddr), .hit(region)
    );

    p_region_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(region));
    p_glob_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        glob_acc |-> gaddr[15:0] == loc_addr);
    p_reg_identity_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_acc && loc_addr < 16'h0800) |-> (gaddr == 23'(loc_addr) && region[RGN_REG]));
    p_top_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_acc && loc_addr[15:14] == 2'b11) |-> gaddr[22:14] == 9'h1FF);
    p_flash_win_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_acc && loc_addr[15:14] == 2'b10) |-> region[RGN_FL]);
endmodule

// File: tb/sim_pg_xlat_top.sv
// Bench: behavioural model of page state and the address map, checked
// every stimulus cycle against the design's outputs.
module sim_pg_xlat_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic [15:0] loc_addr = 16'd0;
    logic        glob_acc = 1'b0;
    logic [1:0]  map_mode = 2'd0;
    logic [22:0] gaddr;
    logic [4:0]  region;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int m_rp = 'hFD, m_ep = 'hFE, m_pp = 'hFE, m_gp = 0;

    always #5 clk = ~clk;

    pg_xlat_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .loc_addr(loc_addr), .glob_acc(glob_acc),
        .map_mode(map_mode), .gaddr(gaddr), .region(region)
    );

    function automatic int ref_ga(int a, bit g, int md, output string tag);
        if (g) begin tag = "R8"; return m_gp * 65536 + a; end
        if (a < 'h0800) begin tag = "R2"; return a; end
        if (a < 'h0C00) begin tag = "R4"; return 'h100000 + m_ep * 1024 + (a - 'h0800); end
        if (a < 'h1000) begin tag = "R6"; return 'h13FC00 + (a - 'h0C00); end
        if (a < 'h2000) begin tag = "R3"; return m_rp * 4096 + (a - 'h1000); end
        if (a < 'h4000) begin tag = "R6"; return 'h0FE000 + (a - 'h2000); end
        if (a < 'h8000) begin
            tag = "R7";
            if (md == 1) return 'h0FC000 + (a - 'h4000);
            if (md == 2) return 'h144000 + (a - 'h4000);
            return 'h7F4000 + (a - 'h4000);
        end
        if (a < 'hC000) begin tag = "R5"; return 'h400000 + m_pp * 16384 + (a - 'h8000); end
        tag = "R6";
        return 'h7FC000 + (a - 'hC000);
    endfunction

    function automatic int ref_rgn(int ga);
        if (ga < 'h800)    return 1;
        if (ga < 'h100000) return 2;
        if (ga < 'h140000) return 4;
        if (ga < 'h400000) return 8;
        return 16;
    endfunction

    // Drive one cycle of stimulus, check outputs, then update the model
    task automatic step(int a, bit g, int md, bit we, int sel, int d, string force_tag);
        string tag;
        int exp_ga;
        int exp_rg;
        @(negedge clk);
        loc_addr = 16'(a); glob_acc = g; map_mode = 2'(md);
        wr_en = we; wr_sel = 2'(sel); wr_data = 8'(d);
        #1;
        exp_ga = ref_ga(a, g, md, tag);
        if (force_tag != "") tag = force_tag;
        exp_rg = ref_rgn(exp_ga);
        total++;
        if (int'(gaddr) != exp_ga) begin
            bad++;
            $display("FAIL %s gaddr loc=%h mode=%0d glob=%0d actual=%h expected=%h",
                     tag, a, md, g, gaddr, exp_ga);
        end
        total++;
        if (int'(region) != exp_rg) begin
            bad++;
            $display("FAIL R10 region ga=%h actual=%b expected=%b", exp_ga, region, 5'(exp_rg));
        end
        if (we && rst_n) begin
            case (sel)
                0: m_rp = d;
                1: m_ep = d;
                2: m_pp = d;
                default: m_gp = d & 'h7F;
            endcase
        end
    endtask

    task automatic sweep(string t);
        int edges[18] = '{'h0000, 'h07FF, 'h0800, 'h0BFF, 'h0C00, 'h0FFF,
                          'h1000, 'h1FFF, 'h2000, 'h2FFF, 'h3000, 'h3FFF,
                          'h4000, 'h7FFF, 'h8000, 'hBFFF, 'hC000, 'hFFFF};
        for (int md = 0; md < 4; md++)
            foreach (edges[i]) step(edges[i], 0, md, 0, 0, 0, t);
    endtask

    initial begin
        // R1: values during and after reset
        step('h1000, 0, 0, 0, 0, 0, "R1");
        step('h0800, 0, 0, 0, 0, 0, "R1");
        @(negedge clk); rst_n = 1'b1;
        step('h1234, 0, 0, 0, 0, 0, "R1");
        step('h0A00, 0, 0, 0, 0, 0, "R1");
        step('h8000, 0, 0, 0, 0, 0, "R1");
        step('h0000, 1, 0, 0, 0, 0, "R1");
        sweep("");

        // R9: writes to each page register
        step('h1000, 0, 0, 1, 0, 'h00, "R9");
        step('h1000, 0, 0, 1, 1, 'hFF, "R9");
        step('h0800, 0, 0, 1, 2, 'h00, "R9");
        step('h8000, 0, 0, 0, 0, 0, "R9");
        sweep("");
        step('h1ABC, 0, 0, 1, 0, 'h5A, "R9");
        step('h0B55, 0, 0, 1, 1, 'h07, "R9");
        step('hA123, 0, 0, 1, 2, 'hFF, "R9");
        sweep("");
        step('h8000, 0, 0, 1, 2, 'hFD, "R5");
        step('h8000, 0, 0, 0, 0, 0, "R5");

        // R9: strobe low leaves every page unchanged
        step('h1000, 0, 0, 0, 0, 'h11, "R9");
        step('h1000, 0, 0, 0, 1, 'h22, "R9");
        step('h0800, 0, 0, 0, 2, 'h33, "R9");
        step('h9000, 0, 0, 0, 3, 'h44, "R9");
        step('h0000, 1, 0, 0, 0, 0, "R9");

        // R8: global access with bit 7 of the data set
        step('h0000, 1, 1, 1, 3, 'hFE, "R8");
        step('h0000, 1, 2, 0, 0, 0, "R8");
        step('hFFFF, 1, 1, 0, 0, 0, "R8");
        step('h1000, 1, 0, 1, 3, 'h92, "R8");
        step('h4567, 1, 2, 0, 0, 0, "R8");
        step('h0400, 1, 3, 0, 0, 0, "R8");

        // Pseudo-random addresses across all modes
        begin
            int s = 'h1D2C;
            for (int k = 0; k < 200; k++) begin
                s = (s * 1103515245 + 12345) & 'h7FFFFFFF;
                step((s >> 8) & 'hFFFF, ((s >> 4) & 7) == 0, s & 3, 0, 0, 0, "");
            end
        end

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule